// File: doc/BRIEF.md
# Two-Dimensional Eye Scan Readout Engine

This block runs an automatic eye scan over a grid of sampling phases and amplitude offsets. It returns the hit count measured at each grid point through a byte-wide register read port. A host writes a small set of control registers over a simple register bus: address, write strobe, read strobe, write data and registered read data. These registers pick the voltage range, decide whether the host or the automatic state machine controls the eye circuitry, hold the lock-monitor enable and an override bit, and arm and launch the scan.

Once launched, the sequencer first queues four pad bytes. It then visits every phase, and for each phase every offset. At each point it asks an external measurement port for a 16-bit count and queues the count as two bytes into an internal byte FIFO, high byte first. The host drains the FIFO in one of two ways. It can read one streaming register repeatedly, or it can read a pair of registers that give the high and low byte of the current point. The sequencer stalls whenever the FIFO cannot take a whole point, so no result is ever dropped.

Top module: `eye_scan_engine`

## Requirements
- R1: After reset, address 0x1 reads 0x01, address 0x2 reads 0x01, address 0x4 reads 0x00, meas_req_o is low, lock_mon_en_o is 1 and eye_override_o is 0.
- R2: Address 0x1 holds the eye control: bit 0 is auto (1 = automatic control) and bits 2:1 are the voltage range. With auto=1, eye_pwr_o follows auto_pwr_i and eye_vrange_o follows auto_vrange_i. With auto=0, eye_pwr_o is 1 and eye_vrange_o is the host range.
- R3: Address 0x2 holds bit 0 = lock-monitor enable (drives lock_mon_en_o) and bit 1 = override (drives eye_override_o). Both read back.
- R4: Address 0x4 is the scan register: bit 0 is the fast-scan enable, bit 1 is start (write-only, always reads 0) and bit 2 is busy (read-only). A write with bits 1 and 0 both set launches a scan. A write with bit 0 clear never launches one.
- R5: The grid is visited with phase as the outer loop and offset as the inner loop, each running 0 to 63. meas_phase_o and meas_ofs_o stay stable while meas_req_o waits for meas_valid_i. Each point queues meas_count_i[15:8] and then meas_count_i[7:0].
- R6: After every launch, the first four bytes delivered are pad bytes of value 0xA5, ahead of any grid data.
- R7: Each read strobe at address 0x5 returns the next queued byte on bus_rdata_o one cycle later. When nothing is queued, it returns 0x00 and nothing is consumed.
- R8: A read at address 0x6 returns the head byte without consuming it (0x00 if the FIFO is empty). A read at address 0x7 returns the byte after the head and consumes both bytes (0x00, nothing consumed, if fewer than two are queued).
- R9: Reads and writes at addresses other than 0x5 and 0x7 never move the readout position, so an interrupted stream resumes with the next byte.
- R10: meas_req_o is never raised while the FIFO has fewer than two free entries, and no result is lost when the host reads slowly.
- R11: Busy is 1 from launch until the low byte of grid point (63,63) is queued, then 0.
- R12: Writing address 0x4 with bit 0 clear aborts: busy drops, meas_req_o falls and the FIFO is emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 4 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid the cycle after the read strobe |
| meas_req_o | output | 1 | Measurement request |
| meas_phase_o | output | 6 | Phase of the requested point |
| meas_ofs_o | output | 6 | Amplitude offset of the requested point |
| meas_valid_i | input | 1 | Measurement result strobe |
| meas_count_i | input | 16 | Hit count for the requested point |
| auto_pwr_i | input | 1 | Eye circuit power request from the automatic state machine |
| auto_vrange_i | input | 2 | Voltage range from the automatic state machine |
| eye_pwr_o | output | 1 | Eye circuit power enable |
| eye_vrange_o | output | 2 | Selected voltage range |
| lock_mon_en_o | output | 1 | Lock-monitor enable |
| eye_override_o | output | 1 | Override control bit |

## Verification
The bench starts a full scan and leaves the FIFO full for a long time. A design that kept requesting without room would drop or overwrite points, and the 8192-byte order check would show a gap. In the middle of the stream, the bench reads the control and high-byte registers and then resumes. A design that advanced on those reads, or that consumed a byte on an empty read, would skip data. Split mode is checked for a high-byte read that must not consume, and for a low-byte read that must consume two. An abort followed by a relaunch must empty the FIFO and bring the four pad bytes back. A design that kept stale bytes or restarted the grid late would show up there.

// File: rtl/eye_scan_pkg.sv
package eye_scan_pkg;
  localparam logic [3:0] A_CFG    = 4'h1;
  localparam logic [3:0] A_MON    = 4'h2;
  localparam logic [3:0] A_SCAN   = 4'h4;
  localparam logic [3:0] A_STREAM = 4'h5;
  localparam logic [3:0] A_HI     = 4'h6;
  localparam logic [3:0] A_LO     = 4'h7;

  localparam logic [7:0] PAD_BYTE = 8'hA5;
  localparam int unsigned PAD_LEN = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_PAD, S_GATE, S_REQ, S_LO
  } seq_state_e;
endpackage

// File: rtl/eye_scan_regs.sv
module eye_scan_regs
  import eye_scan_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       auto_pwr_i,
  input  logic [1:0] auto_vrange_i,
  output logic       auto_ctl_o,
  output logic [1:0] vrange_o,
  output logic       lock_mon_o,
  output logic       override_o,
  output logic       fast_en_o,
  output logic       start_o,
  output logic       abort_o,
  output logic       eye_pwr_o,
  output logic [1:0] eye_vrange_o
);
  logic       cfg_we, mon_we, scan_we;
  logic       auto_q, lock_q, ovr_q, fast_q;
  logic [1:0] vr_q;

  assign cfg_we  = wr_i && (addr_i == A_CFG);
  assign mon_we  = wr_i && (addr_i == A_MON);
  assign scan_we = wr_i && (addr_i == A_SCAN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_q <= 1'b1;
      vr_q   <= 2'b00;
    end else if (cfg_we) begin
      auto_q <= wdata_i[0];
      vr_q   <= wdata_i[2:1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b1;
      ovr_q  <= 1'b0;
    end else if (mon_we) begin
      lock_q <= wdata_i[0];
      ovr_q  <= wdata_i[1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      fast_q <= 1'b0;
    else if (scan_we) fast_q <= wdata_i[0];
  end

  // start needs the enable in the same written value; a cleared enable aborts
  assign start_o = scan_we && wdata_i[1] && wdata_i[0];
  assign abort_o = scan_we && !wdata_i[0];

  assign auto_ctl_o   = auto_q;
  assign vrange_o     = vr_q;
  assign lock_mon_o   = lock_q;
  assign override_o   = ovr_q;
  assign fast_en_o    = fast_q;
  assign eye_pwr_o    = auto_q ? auto_pwr_i : 1'b1;
  assign eye_vrange_o = auto_q ? auto_vrange_i : vr_q;

  p_start_arms_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> fast_en_o);
  p_abort_disarms_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !fast_en_o);
endmodule

// File: rtl/eye_scan_fifo.sv
module eye_scan_fifo #(
  parameter int unsigned DEPTH = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic                         push_i,
  input  logic [7:0]                   wdata_i,
  input  logic                         pop1_i,
  input  logic                         pop2_i,
  output logic [7:0]                   head_o,
  output logic [7:0]                   next_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q, wr_d, rd_d;
  logic [CW-1:0] cnt_q, cnt_d, dec;

  always_comb begin
    dec = pop2_i ? CW'(2) : (pop1_i ? CW'(1) : CW'(0));
    if (flush_i) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      wr_d  = push_i ? wr_q + AW'(1) : wr_q;
      rd_d  = rd_q + AW'(dec);
      cnt_d = cnt_q + CW'(push_i) - dec;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem[wr_q] <= wdata_i;
  end

  assign head_o  = mem[rd_q];
  assign next_o  = mem[rd_q + AW'(1)];
  assign count_o = cnt_q;

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !flush_i) |-> (cnt_q < CW'(DEPTH)));
  p_pop1_guard_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop1_i |-> (cnt_q != '0));
  p_pop2_guard_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop2_i |-> (cnt_q >= CW'(2)));
endmodule

// File: rtl/eye_scan_seq.sv
module eye_scan_seq
  import eye_scan_pkg::*;
#(
  parameter int unsigned PHASE_W = 6,
  parameter int unsigned OFS_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               abort_i,
  input  logic               room_ok_i,
  input  logic               meas_valid_i,
  input  logic [15:0]        meas_count_i,
  output logic               push_o,
  output logic [7:0]         push_data_o,
  output logic               meas_req_o,
  output logic [PHASE_W-1:0] meas_phase_o,
  output logic [OFS_W-1:0]   meas_ofs_o,
  output logic               busy_o
);
  localparam int unsigned PW = $clog2(PAD_LEN);
  localparam logic [PHASE_W-1:0] PH_LAST  = '1;
  localparam logic [OFS_W-1:0]   OFS_LAST = '1;

  seq_state_e         state_q, state_d;
  logic [PW-1:0]      pad_q, pad_d;
  logic [PHASE_W-1:0] ph_q, ph_d;
  logic [OFS_W-1:0]   ofs_q, ofs_d;
  logic [7:0]         lsb_q, lsb_d;

  always_comb begin
    state_d     = state_q;
    pad_d       = pad_q;
    ph_d        = ph_q;
    ofs_d       = ofs_q;
    lsb_d       = lsb_q;
    push_o      = 1'b0;
    push_data_o = PAD_BYTE;
    unique case (state_q)
      S_PAD: begin
        push_o = 1'b1;
        pad_d  = pad_q + PW'(1);
        if (pad_q == PW'(PAD_LEN - 1)) state_d = S_GATE;
      end
      S_GATE: if (room_ok_i) state_d = S_REQ;
      S_REQ: begin
        if (meas_valid_i) begin
          push_o      = 1'b1;
          push_data_o = meas_count_i[15:8];
          lsb_d       = meas_count_i[7:0];
          state_d     = S_LO;
        end
      end
      S_LO: begin
        push_o      = 1'b1;
        push_data_o = lsb_q;
        ofs_d       = ofs_q + OFS_W'(1);
        state_d     = S_GATE;
        if (ofs_q == OFS_LAST) begin
          ph_d = ph_q + PHASE_W'(1);
          if (ph_q == PH_LAST) state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (abort_i) begin
      state_d = S_IDLE;
      push_o  = 1'b0;
    end
    if (start_i) begin
      state_d = S_PAD;
      pad_d   = '0;
      ph_d    = '0;
      ofs_d   = '0;
      push_o  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pad_q   <= '0;
      ph_q    <= '0;
      ofs_q   <= '0;
      lsb_q   <= '0;
    end else begin
      state_q <= state_d;
      pad_q   <= pad_d;
      ph_q    <= ph_d;
      ofs_q   <= ofs_d;
      lsb_q   <= lsb_d;
    end
  end

  assign meas_req_o   = (state_q == S_REQ);
  assign meas_phase_o = ph_q;
  assign meas_ofs_o   = ofs_q;
  assign busy_o       = (state_q != S_IDLE);

  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_req_o && !meas_valid_i && !abort_i && !start_i)
      |=> (meas_req_o && $stable(meas_phase_o) && $stable(meas_ofs_o)));
  p_pad_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (abort_i || start_i || (push_o && push_data_o == PAD_BYTE)));
  p_busy_start_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  p_abort_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && !start_i) |=> !busy_o);
endmodule

// File: rtl/eye_scan_engine.sv
module eye_scan_engine
  import eye_scan_pkg::*;
#(
  parameter int unsigned PHASE_W    = 6,
  parameter int unsigned OFS_W      = 6,
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [3:0]         bus_addr_i,
  input  logic               bus_wr_i,
  input  logic               bus_rd_i,
  input  logic [7:0]         bus_wdata_i,
  output logic [7:0]         bus_rdata_o,
  output logic               meas_req_o,
  output logic [PHASE_W-1:0] meas_phase_o,
  output logic [OFS_W-1:0]   meas_ofs_o,
  input  logic               meas_valid_i,
  input  logic [15:0]        meas_count_i,
  input  logic               auto_pwr_i,
  input  logic [1:0]         auto_vrange_i,
  output logic               eye_pwr_o,
  output logic [1:0]         eye_vrange_o,
  output logic               lock_mon_en_o,
  output logic               eye_override_o
);
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1);

  logic          rst_meta_q, rst_sync_q;
  logic          auto_ctl, fast_en, start_p, abort_p, flush;
  logic [1:0]    vrange;
  logic          push, pop1, pop2, room_ok, busy;
  logic [7:0]    push_data, head, next, rd_val, rdata_q;
  logic [CW-1:0] fcount;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  eye_scan_regs u_regs (
    .clk_i, .rst_ni(rst_sync_q), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .auto_pwr_i, .auto_vrange_i,
    .auto_ctl_o(auto_ctl), .vrange_o(vrange), .lock_mon_o(lock_mon_en_o),
    .override_o(eye_override_o), .fast_en_o(fast_en), .start_o(start_p),
    .abort_o(abort_p), .eye_pwr_o, .eye_vrange_o
  );

  assign flush   = start_p || abort_p;
  assign room_ok = (fcount <= CW'(FIFO_DEPTH - 2));

  eye_scan_seq #(.PHASE_W(PHASE_W), .OFS_W(OFS_W)) u_seq (
    .clk_i, .rst_ni(rst_sync_q), .start_i(start_p), .abort_i(abort_p),
    .room_ok_i(room_ok), .meas_valid_i, .meas_count_i,
    .push_o(push), .push_data_o(push_data), .meas_req_o,
    .meas_phase_o, .meas_ofs_o, .busy_o(busy)
  );

  eye_scan_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni(rst_sync_q), .flush_i(flush), .push_i(push),
    .wdata_i(push_data), .pop1_i(pop1), .pop2_i(pop2),
    .head_o(head), .next_o(next), .count_o(fcount)
  );

  always_comb begin
    rd_val = 8'h00;
    pop1   = 1'b0;
    pop2   = 1'b0;
    unique case (bus_addr_i)
      A_CFG:  rd_val = {5'b0, vrange, auto_ctl};
      A_MON:  rd_val = {6'b0, eye_override_o, lock_mon_en_o};
      A_SCAN: rd_val = {5'b0, busy, 1'b0, fast_en};
      A_STREAM: if (fcount != '0) begin
        rd_val = head;
        pop1   = bus_rd_i;
      end
      A_HI: if (fcount != '0) rd_val = head;
      A_LO: if (fcount >= CW'(2)) begin
        rd_val = next;
        pop2   = bus_rd_i;
      end
      default: rd_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= 8'h00;
    else if (bus_rd_i)  rdata_q <= rd_val;
  end
  assign bus_rdata_o = rdata_q;

  p_req_needs_fast_r12: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    meas_req_o |-> fast_en);
  p_req_room_r10: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    meas_req_o |-> (fcount <= CW'(FIFO_DEPTH - 2)));
endmodule

// File: tb/eye_scan_engine_bench.sv
module eye_scan_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  addr;
  logic        wr, rd;
  logic [7:0]  wdata, rdata;
  logic        meas_req, meas_valid;
  logic [5:0]  meas_phase, meas_ofs;
  logic [15:0] meas_count;
  logic        auto_pwr;
  logic [1:0]  auto_vr, eye_vr;
  logic        eye_pwr, lock_mon, ovr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  int dly      = 0;

  always #2 clk = ~clk;

  eye_scan_engine u_eye_scan_engine (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_rd_i(rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .meas_req_o(meas_req), .meas_phase_o(meas_phase), .meas_ofs_o(meas_ofs),
    .meas_valid_i(meas_valid), .meas_count_i(meas_count),
    .auto_pwr_i(auto_pwr), .auto_vrange_i(auto_vr),
    .eye_pwr_o(eye_pwr), .eye_vrange_o(eye_vr),
    .lock_mon_en_o(lock_mon), .eye_override_o(ovr)
  );

  // measurement model: answers two cycles after a request with a count
  // whose bytes are never zero
  always @(negedge clk) begin
    if (!meas_req || meas_valid) begin
      meas_valid <= 1'b0;
      dly        <= 0;
    end else if (dly == 2) begin
      meas_valid <= 1'b1;
      meas_count <= {2'b10, meas_phase, 2'b01, meas_ofs};
    end else begin
      dly <= dly + 1;
    end
  end

  function automatic logic [7:0] exp_byte(int k);
    int pt = k / 2;
    logic [5:0] ph = 6'(pt / 64);
    logic [5:0] of = 6'(pt % 64);
    return (k % 2 == 0) ? {2'b10, ph} : {2'b01, of};
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic bus_wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  // repeat reads until a nonzero byte appears (zero means nothing queued)
  task automatic bus_rd_nz(logic [3:0] a, output logic [7:0] d);
    d = 8'h00;
    for (int i = 0; i < 200 && d == 8'h00; i++) bus_rd(a, d);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    bus_rd(4'h1, d); check(d == 8'h01, "R1 cfg reset", d, 8'h01);
    bus_rd(4'h2, d); check(d == 8'h01, "R1 mon reset", d, 8'h01);
    bus_rd(4'h4, d); check(d == 8'h00, "R1 scan reset", d, 8'h00);
    check(!meas_req && lock_mon && !ovr, "R1 outputs", {meas_req, lock_mon, ovr}, 3'b010);
    bus_rd(4'h5, d); check(d == 8'h00, "R7 empty stream read", d, 8'h00);
  endtask

  task automatic t_cfg_arb;
    logic [7:0] d;
    auto_pwr = 1'b0; auto_vr = 2'd1;
    bus_wr(4'h1, 8'h04);
    bus_rd(4'h1, d); check(d == 8'h04, "R2 cfg readback", d, 8'h04);
    check(eye_pwr && eye_vr == 2'd2, "R2 host control", {eye_pwr, eye_vr}, 3'b110);
    bus_wr(4'h1, 8'h05);
    check(!eye_pwr && eye_vr == 2'd1, "R2 auto control", {eye_pwr, eye_vr}, 3'b001);
    auto_pwr = 1'b1; auto_vr = 2'd3;
    @(negedge clk);
    check(eye_pwr && eye_vr == 2'd3, "R2 auto follows", {eye_pwr, eye_vr}, 3'b111);
    bus_wr(4'h1, 8'h01);
  endtask

  task automatic t_mon;
    logic [7:0] d;
    bus_wr(4'h2, 8'h02);
    bus_rd(4'h2, d); check(d == 8'h02, "R3 mon readback", d, 8'h02);
    check(!lock_mon && ovr, "R3 mon outputs", {lock_mon, ovr}, 2'b01);
    bus_wr(4'h2, 8'h01);
    check(lock_mon && !ovr, "R3 mon restore", {lock_mon, ovr}, 2'b10);
  endtask

  task automatic t_start_ignored;
    logic [7:0] d;
    bus_wr(4'h4, 8'h02);
    repeat (10) @(negedge clk);
    check(!meas_req, "R4 start without enable", meas_req, 0);
    bus_rd(4'h4, d); check(d == 8'h00, "R4 no launch", d, 8'h00);
  endtask

  task automatic t_stream_scan;
    logic [7:0] d;
    bus_wr(4'h4, 8'h03);
    bus_rd(4'h4, d); check(d == 8'h05, "R4 start self-clears, R11 busy", d, 8'h05);
    repeat (300) @(negedge clk);
    check(!meas_req, "R10 stall on full FIFO", meas_req, 0);
    for (int i = 0; i < 4; i++) begin
      bus_rd_nz(4'h5, d); check(d == 8'hA5, "R6 pad byte", d, 8'hA5);
    end
    for (int k = 0; k < 8192; k++) begin
      if (k == 1001) begin
        bus_rd(4'h1, d);
        bus_rd_nz(4'h6, d); check(d == exp_byte(k), "R9 peek mid-stream", d, exp_byte(k));
      end
      bus_rd_nz(4'h5, d);
      check(d == exp_byte(k), "R5 R7 stream order", d, exp_byte(k));
    end
    repeat (20) @(negedge clk);
    bus_rd(4'h4, d); check(d == 8'h01, "R11 busy cleared", d, 8'h01);
    bus_rd(4'h5, d); check(d == 8'h00, "R7 drained", d, 8'h00);
  endtask

  task automatic t_split_abort;
    logic [7:0] d;
    bus_wr(4'h4, 8'h03);
    for (int i = 0; i < 2; i++) begin
      bus_rd_nz(4'h6, d); check(d == 8'hA5, "R6 split pad hi", d, 8'hA5);
      bus_rd_nz(4'h7, d); check(d == 8'hA5, "R6 split pad lo", d, 8'hA5);
    end
    for (int p = 0; p < 200; p++) begin
      bus_rd_nz(4'h6, d); check(d == exp_byte(2*p), "R8 split hi", d, exp_byte(2*p));
      bus_rd(4'h6, d);    check(d == exp_byte(2*p), "R8 hi no advance", d, exp_byte(2*p));
      bus_rd_nz(4'h7, d); check(d == exp_byte(2*p+1), "R8 split lo", d, exp_byte(2*p+1));
    end
    bus_wr(4'h4, 8'h00);
    repeat (3) @(negedge clk);
    check(!meas_req, "R12 request dropped", meas_req, 0);
    bus_rd(4'h4, d); check(d == 8'h00, "R12 busy cleared", d, 8'h00);
    bus_rd(4'h5, d); check(d == 8'h00, "R12 FIFO flushed", d, 8'h00);
  endtask

  task automatic t_restart;
    logic [7:0] d;
    bus_wr(4'h4, 8'h03);
    for (int i = 0; i < 4; i++) begin
      bus_rd_nz(4'h5, d); check(d == 8'hA5, "R6 pads after relaunch", d, 8'hA5);
    end
    bus_rd_nz(4'h5, d); check(d == 8'h80, "R5 grid restarts hi", d, 8'h80);
    bus_rd_nz(4'h5, d); check(d == 8'h40, "R5 grid restarts lo", d, 8'h40);
    bus_wr(4'h4, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0;
    meas_valid = 1'b0; meas_count = '0; auto_pwr = 1'b0; auto_vr = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_cfg_arb();
    t_mon();
    t_start_ignored();
    t_stream_scan();
    t_split_abort();
    t_restart();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule